// File: doc/BRIEF.md
# Serial Link Power-State Manager for a One-Host, Multi-Device Port Multiplier

This block sets the power state of every serial link in a port multiplier: one host-facing link and `NDEV` device-facing links. Each link is Active, Partial or Slumber. The block takes already-decoded primitive events on each port: a Partial request, a Slumber request, an acknowledge, a negative acknowledge, PHY-ready and a wake indication. It returns one-cycle requests to send acknowledge, negative-acknowledge or power-request primitives, and it drives the power-down controls of each link.

A power request from the host is answered to the host and changes the host link's state. It is then forwarded only to device ports whose PHY is ready. Each device link takes the new state only when that device acknowledges, and it must do so within a configurable number of cycles. A power request from a device is answered to that device and changes only that device's link.

When the host PHY is not ready, the host-side PHY is powered down and the device transmitters are squelched. Out-of-band signalling stays powered in every state.

Top module: `pm_link_power_mgr`

## Requirements
- R1: After synchronous reset every link is Active (state code 2'b00). No acknowledge, negative-acknowledge or request pulse is driven. State codes are 2'b00 Active, 2'b01 Partial and 2'b10 Slumber. Device link i occupies bits [2i+1:2i] of `dev_pwr`.
- R2: The pipeline-down control of a link is high exactly when its state is not Active. The PLL-down control is high exactly when its state is Slumber. OOB logic is never powered down.
- R3: A host request arriving while the host link is Active and no forward is outstanding produces a one-cycle `host_send_ack` on the next clock. The host link takes the requested state on that same clock.
- R4: An accepted host request raises `dev_send_req_p` or `dev_send_req_s` for one cycle, in the same cycle as the host acknowledge. This happens for exactly the devices whose `dev_phy_rdy` bit was high in the request cycle. No other device receives it.
- R5: A device link that was sent a forwarded request takes the requested state only if that device's `dev_ack` bit arrives while the forward is outstanding. A `dev_nak` ends the forward and leaves the link unchanged.
- R6: A forward with no answer within `TIMEOUT` cycles after it is sent is abandoned. The device link stays Active, and an acknowledge arriving later has no effect.
- R7: A device request on an Active, idle device link produces a one-cycle acknowledge to that device and sets its state. The host link and all other device links are unchanged.
- R8: A request is answered with a negative acknowledge, and changes no state, in four cases: the target link is not Active; for the host, any forward is outstanding; for a device, its own forward is outstanding; or a host request is forwarded to that device in the same cycle.
- R9: A wake indication on a link returns it to Active on the next clock and clears its power-down controls. A device wake also abandons any outstanding forward to that device.
- R10: One clock after `host_phy_rdy` is low, the host pipeline-down and PLL-down controls are high and every device transmitter squelch is high. Both clear one clock after it returns high.
- R11: When the Partial and Slumber request inputs of a port are high together, the request is treated as Slumber.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req_p | input | 1 | Host asks for Partial |
| host_req_s | input | 1 | Host asks for Slumber |
| host_wake | input | 1 | Host link wake indication |
| host_phy_rdy | input | 1 | Host PHY ready |
| dev_req_p | input | NDEV | Device asks for Partial |
| dev_req_s | input | NDEV | Device asks for Slumber |
| dev_ack | input | NDEV | Device acknowledged a forwarded request |
| dev_nak | input | NDEV | Device refused a forwarded request |
| dev_wake | input | NDEV | Device link wake indication |
| dev_phy_rdy | input | NDEV | Device PHY ready |
| host_send_ack | output | 1 | Send acknowledge to host |
| host_send_nak | output | 1 | Send negative acknowledge to host |
| host_pwr | output | 2 | Host link state code |
| host_pipe_dn | output | 1 | Host pipelines powered down |
| host_pll_dn | output | 1 | Host PLL powered down |
| dev_send_ack | output | NDEV | Send acknowledge to device |
| dev_send_nak | output | NDEV | Send negative acknowledge to device |
| dev_send_req_p | output | NDEV | Forward Partial request to device |
| dev_send_req_s | output | NDEV | Forward Slumber request to device |
| dev_pwr | output | 2*NDEV | Device link state codes |
| dev_pipe_dn | output | NDEV | Device pipelines powered down |
| dev_pll_dn | output | NDEV | Device PLL powered down |
| dev_tx_squelch | output | NDEV | Device transmitter squelch |

## Verification
Host requests are issued under three PHY-ready masks (both devices ready, one ready, none considered busy) and are answered by acknowledge, refusal and silence. This separates correct fan-out from broadcast, and ack-gated state change from an unconditional one. Device requests are given while the link is Active, while it is already low, and in the same cycle as a host forward. These cases show that only the requesting link moves and that conflicts are refused. A late acknowledge after the timeout, a host request during an outstanding forward, combined Partial-and-Slumber requests, and a dropped host PHY-ready cover the remaining orderings.

// File: rtl/pmlp_pkg.sv
package pmlp_pkg;

  typedef enum logic [1:0] {
    PWR_ACTIVE  = 2'b00,
    PWR_PARTIAL = 2'b01,
    PWR_SLUMBER = 2'b10
  } pwr_e;

  // Slumber wins when both request kinds arrive together
  function automatic pwr_e req_target(input logic want_slumber);
    return want_slumber ? PWR_SLUMBER : PWR_PARTIAL;
  endfunction

  function automatic logic pipe_off(input pwr_e s);
    return s != PWR_ACTIVE;
  endfunction

  function automatic logic pll_off(input pwr_e s);
    return s == PWR_SLUMBER;
  endfunction

endpackage

// File: rtl/pmlp_host_link.sv
module pmlp_host_link
  import pmlp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_p,
  input  logic       req_s,
  input  logic       wake,
  input  logic       busy,
  input  logic       phy_rdy,
  output logic       accept,
  output logic       send_ack,
  output logic       send_nak,
  output logic [1:0] state_o,
  output logic       pipe_dn,
  output logic       pll_dn,
  output logic       squelch
);

  pwr_e state;
  logic phy_q;
  logic any_req;

  assign any_req = req_p | req_s;
  assign accept  = any_req & (state == PWR_ACTIVE) & ~busy & ~wake;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PWR_ACTIVE;
      send_ack <= 1'b0;
      send_nak <= 1'b0;
      phy_q    <= 1'b0;
    end else begin
      phy_q    <= phy_rdy;
      send_ack <= accept;
      send_nak <= any_req & ~accept;
      if (wake)
        state <= PWR_ACTIVE;
      else if (accept)
        state <= req_target(req_s);
    end
  end

  assign state_o = state;
  assign pipe_dn = pipe_off(state) | ~phy_q;
  assign pll_dn  = pll_off(state) | ~phy_q;
  assign squelch = ~phy_q;

endmodule

// File: rtl/pmlp_dev_link.sv
module pmlp_dev_link
  import pmlp_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fwd_go,
  input  logic       fwd_slumber,
  input  logic       req_p,
  input  logic       req_s,
  input  logic       rsp_ack,
  input  logic       rsp_nak,
  input  logic       wake,
  output logic       send_ack,
  output logic       send_nak,
  output logic       send_req_p,
  output logic       send_req_s,
  output logic       pending_o,
  output logic [1:0] state_o,
  output logic       pipe_dn,
  output logic       pll_dn
);

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] TLOAD = TW'(TIMEOUT);
  localparam logic [TW-1:0] TONE  = TW'(1);

  pwr_e          state;
  pwr_e          fwd_tgt;
  logic          pending;
  logic [TW-1:0] timer;
  logic          any_req;
  logic          dev_accept;

  assign any_req    = req_p | req_s;
  assign dev_accept = any_req & (state == PWR_ACTIVE) & ~pending & ~fwd_go & ~wake;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PWR_ACTIVE;
      fwd_tgt    <= PWR_ACTIVE;
      pending    <= 1'b0;
      timer      <= '0;
      send_ack   <= 1'b0;
      send_nak   <= 1'b0;
      send_req_p <= 1'b0;
      send_req_s <= 1'b0;
    end else begin
      send_ack   <= dev_accept;
      send_nak   <= any_req & ~dev_accept;
      send_req_p <= 1'b0;
      send_req_s <= 1'b0;
      if (wake) begin
        state   <= PWR_ACTIVE;
        pending <= 1'b0;
        timer   <= '0;
      end else if (pending) begin
        if (rsp_ack) begin
          state   <= fwd_tgt;
          pending <= 1'b0;
        end else if (rsp_nak || timer == TONE) begin
          pending <= 1'b0;
        end else begin
          timer <= timer - TONE;
        end
      end else if (fwd_go) begin
        pending    <= 1'b1;
        timer      <= TLOAD;
        fwd_tgt    <= req_target(fwd_slumber);
        send_req_p <= ~fwd_slumber;
        send_req_s <= fwd_slumber;
      end else if (dev_accept) begin
        state <= req_target(req_s);
      end
    end
  end

  assign pending_o = pending;
  assign state_o   = state;
  assign pipe_dn   = pipe_off(state);
  assign pll_dn    = pll_off(state);

endmodule

// File: rtl/pm_link_power_mgr.sv
module pm_link_power_mgr #(
  parameter int NDEV    = 2,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req_p,
  input  logic              host_req_s,
  input  logic              host_wake,
  input  logic              host_phy_rdy,
  input  logic [NDEV-1:0]   dev_req_p,
  input  logic [NDEV-1:0]   dev_req_s,
  input  logic [NDEV-1:0]   dev_ack,
  input  logic [NDEV-1:0]   dev_nak,
  input  logic [NDEV-1:0]   dev_wake,
  input  logic [NDEV-1:0]   dev_phy_rdy,
  output logic              host_send_ack,
  output logic              host_send_nak,
  output logic [1:0]        host_pwr,
  output logic              host_pipe_dn,
  output logic              host_pll_dn,
  output logic [NDEV-1:0]   dev_send_ack,
  output logic [NDEV-1:0]   dev_send_nak,
  output logic [NDEV-1:0]   dev_send_req_p,
  output logic [NDEV-1:0]   dev_send_req_s,
  output logic [2*NDEV-1:0] dev_pwr,
  output logic [NDEV-1:0]   dev_pipe_dn,
  output logic [NDEV-1:0]   dev_pll_dn,
  output logic [NDEV-1:0]   dev_tx_squelch
);

  logic            host_accept;
  logic            host_squelch;
  logic [NDEV-1:0] dev_pending;
  logic            any_pending;

  assign any_pending = |dev_pending;

  pmlp_host_link u_host (
    .clk      (clk),
    .rst      (rst),
    .req_p    (host_req_p),
    .req_s    (host_req_s),
    .wake     (host_wake),
    .busy     (any_pending),
    .phy_rdy  (host_phy_rdy),
    .accept   (host_accept),
    .send_ack (host_send_ack),
    .send_nak (host_send_nak),
    .state_o  (host_pwr),
    .pipe_dn  (host_pipe_dn),
    .pll_dn   (host_pll_dn),
    .squelch  (host_squelch)
  );

  for (genvar gi = 0; gi < NDEV; gi++) begin : g_dev
    pmlp_dev_link #(.TIMEOUT(TIMEOUT)) u_dev (
      .clk         (clk),
      .rst         (rst),
      .fwd_go      (host_accept & dev_phy_rdy[gi]),
      .fwd_slumber (host_req_s),
      .req_p       (dev_req_p[gi]),
      .req_s       (dev_req_s[gi]),
      .rsp_ack     (dev_ack[gi]),
      .rsp_nak     (dev_nak[gi]),
      .wake        (dev_wake[gi]),
      .send_ack    (dev_send_ack[gi]),
      .send_nak    (dev_send_nak[gi]),
      .send_req_p  (dev_send_req_p[gi]),
      .send_req_s  (dev_send_req_s[gi]),
      .pending_o   (dev_pending[gi]),
      .state_o     (dev_pwr[2*gi +: 2]),
      .pipe_dn     (dev_pipe_dn[gi]),
      .pll_dn      (dev_pll_dn[gi])
    );
    assign dev_tx_squelch[gi] = host_squelch;
  end

endmodule

// File: rtl/pmlp_checker.sv
module pmlp_checker #(
  parameter int NDEV = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wake,
  input logic [NDEV-1:0]   dev_ack,
  input logic [NDEV-1:0]   dev_phy_rdy,
  input logic              host_send_ack,
  input logic              host_send_nak,
  input logic [1:0]        host_pwr,
  input logic [NDEV-1:0]   dev_send_ack,
  input logic [NDEV-1:0]   dev_send_req_p,
  input logic [NDEV-1:0]   dev_send_req_s,
  input logic [2*NDEV-1:0] dev_pwr,
  input logic [NDEV-1:0]   dev_pipe_dn,
  input logic [NDEV-1:0]   dev_pll_dn
);

  a_r8_ack_nak_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(host_send_ack && host_send_nak));

  a_r2_pll_implies_pipe: assert property (@(posedge clk) disable iff (rst)
    (dev_pll_dn & ~dev_pipe_dn) == '0);

  a_r9_host_wake_active: assert property (@(posedge clk) disable iff (rst)
    host_wake |=> host_pwr == 2'b00);

  a_r3_host_low_needs_ack: assert property (@(posedge clk) disable iff (rst)
    (host_pwr != 2'b00 && $past(host_pwr) == 2'b00) |-> host_send_ack);

  a_r4_forward_only_ready: assert property (@(posedge clk) disable iff (rst)
    ((dev_send_req_p | dev_send_req_s) & ~$past(dev_phy_rdy)) == '0);

  for (genvar gi = 0; gi < NDEV; gi++) begin : g_chk
    // R5 and R7: a device link leaves Active only via its ack or an own accepted request
    a_r5_dev_low_needs_ack: assert property (@(posedge clk) disable iff (rst)
      (dev_pwr[2*gi +: 2] != 2'b00 && $past(dev_pwr[2*gi +: 2]) == 2'b00)
        |-> ($past(dev_ack[gi]) || dev_send_ack[gi]));
  end

endmodule

bind pm_link_power_mgr pmlp_checker #(.NDEV(NDEV)) u_pmlp_checker (
  .clk            (clk),
  .rst            (rst),
  .host_wake      (host_wake),
  .dev_ack        (dev_ack),
  .dev_phy_rdy    (dev_phy_rdy),
  .host_send_ack  (host_send_ack),
  .host_send_nak  (host_send_nak),
  .host_pwr       (host_pwr),
  .dev_send_ack   (dev_send_ack),
  .dev_send_req_p (dev_send_req_p),
  .dev_send_req_s (dev_send_req_s),
  .dev_pwr        (dev_pwr),
  .dev_pipe_dn    (dev_pipe_dn),
  .dev_pll_dn     (dev_pll_dn)
);

// File: tb/pm_link_power_mgr_bench.sv
module pm_link_power_mgr_bench;

  localparam int NDEV = 2;
  localparam int TO   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req_p = 0, host_req_s = 0, host_wake = 0, host_phy_rdy = 1;
  logic [NDEV-1:0] dev_req_p = '0, dev_req_s = '0, dev_ack = '0, dev_nak = '0;
  logic [NDEV-1:0] dev_wake = '0, dev_phy_rdy = '1;
  logic host_send_ack, host_send_nak, host_pipe_dn, host_pll_dn;
  logic [1:0] host_pwr;
  logic [NDEV-1:0] dev_send_ack, dev_send_nak, dev_send_req_p, dev_send_req_s;
  logic [NDEV-1:0] dev_pipe_dn, dev_pll_dn, dev_tx_squelch;
  logic [2*NDEV-1:0] dev_pwr;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pm_link_power_mgr #(.NDEV(NDEV), .TIMEOUT(TO)) u_pm_link_power_mgr (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_in();
    host_req_p = 0; host_req_s = 0; host_wake = 0;
    dev_req_p = '0; dev_req_s = '0; dev_ack = '0; dev_nak = '0; dev_wake = '0;
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 host state", 32'(host_pwr), 0);
    chk("R1 dev state", 32'(dev_pwr), 0);
    chk("R1 pulses", 32'({host_send_ack, host_send_nak, dev_send_ack, dev_send_nak,
                          dev_send_req_p, dev_send_req_s}), 0);
    chk("R2 controls active", 32'({host_pipe_dn, host_pll_dn, dev_pipe_dn, dev_pll_dn}), 0);
  endtask

  task automatic t_host_partial_fanout();
    dev_phy_rdy = 2'b11;
    host_req_p = 1; step(); clear_in();
    chk("R3 host ack", 32'({host_send_ack, host_send_nak}), 32'b10);
    chk("R3 host partial", 32'(host_pwr), 1);
    chk("R2 host partial ctl", 32'({host_pipe_dn, host_pll_dn}), 32'b10);
    chk("R4 fwd partial", 32'({dev_send_req_p, dev_send_req_s}), 32'b1100);
    chk("R5 dev waits ack", 32'(dev_pwr), 0);
    dev_ack = 2'b01; dev_nak = 2'b10; step(); clear_in();
    chk("R5 ack vs nak", 32'(dev_pwr), 32'b0001);
    chk("R2 dev partial ctl", 32'({dev_pipe_dn, dev_pll_dn}), 32'b0100);
    chk("R3 ack one cycle", 32'(host_send_ack), 0);
  endtask

  task automatic t_nak_lowpower_and_wake();
    host_req_s = 1; step(); clear_in();
    chk("R8 host nak when low", 32'({host_send_ack, host_send_nak}), 32'b01);
    chk("R8 host state kept", 32'(host_pwr), 1);
    host_wake = 1; dev_wake = 2'b01; step(); clear_in();
    chk("R9 host wake", 32'({host_pwr, host_pipe_dn, host_pll_dn}), 0);
    chk("R9 dev wake", 32'({dev_pwr, dev_pipe_dn}), 0);
  endtask

  task automatic t_timeout_busy();
    dev_phy_rdy = 2'b01;
    host_req_s = 1; step(); clear_in();
    chk("R3 host slumber", 32'(host_pwr), 2);
    chk("R2 host slumber ctl", 32'({host_pipe_dn, host_pll_dn}), 32'b11);
    chk("R4 fwd only ready", 32'({dev_send_req_p, dev_send_req_s}), 32'b0001);
    host_wake = 1; step(); clear_in();
    host_req_p = 1; step(); clear_in();
    chk("R8 host nak busy", 32'({host_send_ack, host_send_nak, host_pwr}), 32'b0100);
    step(TO);
    dev_ack = 2'b01; step(); clear_in();
    chk("R6 late ack ignored", 32'(dev_pwr), 0);
    host_req_p = 1; step(); clear_in();
    chk("R6 forward released", 32'({host_send_ack, dev_send_req_p}), 32'b101);
    dev_nak = 2'b01; step(); clear_in();
    chk("R5 nak keeps active", 32'(dev_pwr), 0);
    host_wake = 1; step(); clear_in();
  endtask

  task automatic t_device_request();
    dev_req_s = 2'b10; step(); clear_in();
    chk("R7 dev ack", 32'({dev_send_ack, dev_send_nak}), 32'b1000);
    chk("R7 only dev1", 32'({host_pwr, dev_pwr}), 32'b001000);
    chk("R2 dev slumber ctl", 32'({dev_pipe_dn, dev_pll_dn}), 32'b1010);
    dev_req_p = 2'b10; step(); clear_in();
    chk("R8 dev nak when low", 32'({dev_send_ack, dev_send_nak, dev_pwr}), 32'b00101000);
    dev_wake = 2'b10; step(); clear_in();
    chk("R9 dev1 wake", 32'(dev_pwr), 0);
  endtask

  task automatic t_conflict_and_both();
    dev_phy_rdy = 2'b11;
    host_req_p = 1; dev_req_p = 2'b01; step(); clear_in();
    chk("R8 same-cycle dev nak", 32'({host_send_ack, dev_send_nak, dev_send_ack}), 32'b10100);
    chk("R4 fwd both", 32'(dev_send_req_p), 32'b11);
    dev_ack = 2'b11; step(); clear_in();
    chk("R5 both acked", 32'(dev_pwr), 32'b0101);
    host_wake = 1; dev_wake = 2'b11; step(); clear_in();
    host_req_p = 1; host_req_s = 1; step(); clear_in();
    chk("R11 host both -> slumber", 32'({host_pwr, dev_send_req_s, dev_send_req_p}), 32'b101100);
    dev_nak = 2'b11; step(); clear_in();
    host_wake = 1; dev_req_p = 2'b01; dev_req_s = 2'b01; step(); clear_in();
    chk("R11 dev both -> slumber", 32'(dev_pwr), 32'b0010);
    dev_wake = 2'b01; step(); clear_in();
  endtask

  task automatic t_host_phy();
    host_phy_rdy = 0; step();
    chk("R10 phy down", 32'({host_pipe_dn, host_pll_dn, dev_tx_squelch}), 32'b1111);
    chk("R10 state kept", 32'(host_pwr), 0);
    host_phy_rdy = 1; step();
    chk("R10 phy back", 32'({host_pipe_dn, host_pll_dn, dev_tx_squelch}), 0);
  endtask

  initial begin
    step(2);
    rst = 0;
    t_reset();
    t_host_partial_fanout();
    t_nak_lowpower_and_wake();
    t_timeout_busy();
    t_device_request();
    t_conflict_and_both();
    t_host_phy();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule